// File: doc/BRIEF.md
# Instruction-Fetch Address Trap Unit

This block watches a processor bus one state at a time. In each state it compares the address of an instruction prefetch with a programmable trap address. Data accesses are never compared. When a prefetch hits the trap address, the block raises a trap interrupt request two states later. The request is held until exception handling begins.

Exception handling does not interrupt an instruction. It starts only after an instruction finishes while the request is up. The instruction-completion strobe comes from outside the block: a simple execution-timing model, or a bench stub. With that strobe the outside logic supplies the address of the next instruction still to execute. The block latches that address as the return address to stack. Because the request lags the prefetch, the stacked address depends on how long the instructions around the trap take. If the preceding instruction is still executing, it is the trap address itself. If the trapped instruction has already finished, it is a later address.

Top module: `at_trap_unit`

## Requirements
- R1: When a prefetch state hits the trap address with the trap enabled, `trap_irq` reads 0 in the state just after the sampling edge and 1 from the state after that. The request therefore appears exactly two states after the prefetch.
- R2: A state is compared only when `bus_valid`=1 and `bus_fetch`=1 (1 = instruction prefetch, 0 = data access). A data access to the trap address, or an idle state carrying it, never raises `trap_irq`.
- R3: The trap register is 24 bits wide and resets to 0. A write on `trap_wr` takes effect from the following state, so a prefetch in the same state as the write is compared with the old value. Address bit 0 is left out of the compare, and all 23 upper bits must match.
- R4: `exc_start` is a one-state pulse. It rises on the edge that samples `insn_done`=1 while `trap_irq`=1 and the trap is enabled. A completion seen while `trap_irq`=0 starts nothing.
- R5: On that edge `stack_addr` takes the value of `resume_pc`, and it keeps that value at all other times.
- R6: Once raised, `trap_irq` stays at 1 through states without completion. It falls on the same edge that raises `exc_start`.
- R7: While a hit is in flight, while `trap_irq` is 1, or during the `exc_start` state, further prefetch hits are ignored and produce no second request.
- R8: With `trap_en`=0, no hit is taken and no exception starts. Clearing it cancels a hit in flight and drops a raised `trap_irq` on the next edge.
- R9: After reset, `trap_irq`=0, `exc_start`=0 and `stack_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 24 | Bus address of this state |
| bus_valid | input | 1 | A bus access occurs in this state |
| bus_fetch | input | 1 | 1 = instruction prefetch, 0 = data access |
| insn_done | input | 1 | An instruction finishes in this state |
| resume_pc | input | 24 | Address of the next instruction still to execute |
| trap_wr | input | 1 | Write strobe for the trap address register |
| trap_wdata | input | 24 | Trap address to write |
| trap_en | input | 1 | Enables the comparator and the request path |
| trap_irq | output | 1 | Trap interrupt request |
| exc_start | output | 1 | One-state pulse: exception handling begins |
| stack_addr | output | 24 | Return address latched at exception start |

## Verification
A wrong delay-line stage shows up at the ports as `trap_irq` rising one state early or late, two states after the faulty prefetch at the latest. A stuck busy term shows up as a lost hit or a doubled request within two states of the repeated fetch. A bad compare mask or a missing fetch qualifier raises a request after a data access or an odd trap value. The exception-control register shows its faults on the completion edge itself, as an early pulse, a missing one, or a `stack_addr` that does not match `resume_pc`. A behavioural model compares all three outputs in every state, so each of these faults is reported in the state where it first shows at the ports.

// File: rtl/at_pkg.sv
package at_pkg;
  localparam int unsigned AT_ADDR_W = 24;
  typedef logic [AT_ADDR_W-1:0] at_addr_t;

  // mask of the address bits that take part in the compare
  function automatic at_addr_t cmp_mask(input int unsigned align_bits);
    at_addr_t m;
    m = '1;
    for (int i = 0; i < int'(align_bits); i++) m[i] = 1'b0;
    return m;
  endfunction

  // true when two addresses select the same aligned instruction word
  function automatic logic same_word(input at_addr_t a, input at_addr_t b,
                                     input int unsigned align_bits);
    return ((a ^ b) & cmp_mask(align_bits)) == '0;
  endfunction
endpackage

// File: rtl/at_trap_reg.sv
module at_trap_reg
  import at_pkg::*;
#(
  parameter at_addr_t RESET_VAL = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  at_addr_t wdata,
  output at_addr_t trap_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  trap_addr <= RESET_VAL;
    else if (wr) trap_addr <= wdata;
  end
endmodule

// File: rtl/at_fetch_cmp.sv
module at_fetch_cmp
  import at_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 1
) (
  input  logic     bus_valid,
  input  logic     bus_fetch,
  input  at_addr_t bus_addr,
  input  at_addr_t trap_addr,
  input  logic     enable,
  input  logic     busy,
  output logic     addr_eq,
  output logic     hit
);
  logic is_fetch_state;

  always_comb begin
    is_fetch_state = bus_valid & bus_fetch;
    addr_eq        = same_word(bus_addr, trap_addr, ALIGN_BITS);
    hit            = is_fetch_state & addr_eq & enable & ~busy;
  end
endmodule

// File: rtl/at_req_delay.sv
module at_req_delay #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hit,
  output logic due,
  output logic in_flight
);
  localparam int unsigned STAGES = (DELAY > 1) ? DELAY - 1 : 1;

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       stage_q[0] <= 1'b0;
          else if (!enable) stage_q[0] <= 1'b0;
          else              stage_q[0] <= hit;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       stage_q[g] <= 1'b0;
          else if (!enable) stage_q[g] <= 1'b0;
          else              stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    due       = stage_q[STAGES-1];
    in_flight = |stage_q;
  end
endmodule

// File: rtl/at_exc_ctl.sv
module at_exc_ctl
  import at_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     due,
  input  logic     insn_done,
  input  at_addr_t resume_pc,
  output logic     take,
  output logic     irq,
  output logic     exc_start,
  output at_addr_t stack_addr
);
  always_comb take = irq & insn_done & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      exc_start  <= 1'b0;
      stack_addr <= '0;
    end else begin
      exc_start <= take;
      if (take) stack_addr <= resume_pc;
      if (!enable || take) irq <= 1'b0;
      else if (due)        irq <= 1'b1;
    end
  end
endmodule

// File: rtl/at_trap_unit.sv
module at_trap_unit
  import at_pkg::*;
#(
  parameter int unsigned REQ_DELAY  = 2,
  parameter int unsigned ALIGN_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AT_ADDR_W-1:0] bus_addr,
  input  logic                 bus_valid,
  input  logic                 bus_fetch,
  input  logic                 insn_done,
  input  logic [AT_ADDR_W-1:0] resume_pc,
  input  logic                 trap_wr,
  input  logic [AT_ADDR_W-1:0] trap_wdata,
  input  logic                 trap_en,
  output logic                 trap_irq,
  output logic                 exc_start,
  output logic [AT_ADDR_W-1:0] stack_addr
);
  at_addr_t trap_addr_w;
  logic     addr_eq_w;
  logic     hit_w;
  logic     due_w;
  logic     in_flight_w;
  logic     take_w;
  logic     busy_w;

  always_comb busy_w = in_flight_w | trap_irq | exc_start;

  at_trap_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (trap_wr),
    .wdata     (trap_wdata),
    .trap_addr (trap_addr_w)
  );

  at_fetch_cmp #(.ALIGN_BITS(ALIGN_BITS)) u_cmp (
    .bus_valid (bus_valid),
    .bus_fetch (bus_fetch),
    .bus_addr  (bus_addr),
    .trap_addr (trap_addr_w),
    .enable    (trap_en),
    .busy      (busy_w),
    .addr_eq   (addr_eq_w),
    .hit       (hit_w)
  );

  at_req_delay #(.DELAY(REQ_DELAY)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (trap_en),
    .hit       (hit_w),
    .due       (due_w),
    .in_flight (in_flight_w)
  );

  at_exc_ctl u_exc (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (trap_en),
    .due        (due_w),
    .insn_done  (insn_done),
    .resume_pc  (resume_pc),
    .take       (take_w),
    .irq        (trap_irq),
    .exc_start  (exc_start),
    .stack_addr (stack_addr)
  );
endmodule

// File: rtl/at_trap_chk.sv
module at_trap_chk
  import at_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     bus_valid,
  input logic     bus_fetch,
  input logic     trap_en,
  input logic     insn_done,
  input at_addr_t resume_pc,
  input logic     hit_w,
  input logic     due_w,
  input logic     in_flight_w,
  input logic     trap_irq,
  input logic     exc_start,
  input at_addr_t stack_addr
);
  // R1
  irq_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(hit_w, 2) && $past(trap_en)) |-> trap_irq);

  // R1
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_irq) |-> $past(due_w));

  // R2
  data_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_fetch) |-> !hit_w);

  // R4
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_start) |-> $past(trap_irq && insn_done && trap_en));

  // R4
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !exc_start);

  // R5
  stack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |-> stack_addr == $past(resume_pc));

  // R5
  stack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_start |-> $stable(stack_addr));

  // R6
  irq_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_irq, exc_start}));

  // R7
  no_rehit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight_w || trap_irq || exc_start) |-> !hit_w);

  // R8
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en |=> (!trap_irq && !exc_start && !in_flight_w));
endmodule

bind at_trap_unit at_trap_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_fetch   (bus_fetch),
  .trap_en     (trap_en),
  .insn_done   (insn_done),
  .resume_pc   (resume_pc),
  .hit_w       (hit_w),
  .due_w       (due_w),
  .in_flight_w (in_flight_w),
  .trap_irq    (trap_irq),
  .exc_start   (exc_start),
  .stack_addr  (stack_addr)
);

// File: tb/test_at_trap_unit.sv
module test_at_trap_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 2;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_valid = 1'b0;
  logic        bus_fetch = 1'b0;
  logic        insn_done = 1'b0;
  logic [23:0] resume_pc = '0;
  logic        trap_wr = 1'b0;
  logic [23:0] trap_wdata = '0;
  logic        trap_en = 1'b0;
  logic        trap_irq;
  logic        exc_start;
  logic [23:0] stack_addr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model state
  int          m_age = 0;
  bit          m_irq = 1'b0;
  bit          m_exc = 1'b0;
  logic [23:0] m_stack = '0;
  logic [23:0] m_trap = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  at_trap_unit i_at_trap_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_valid  (bus_valid),
    .bus_fetch  (bus_fetch),
    .insn_done  (insn_done),
    .resume_pc  (resume_pc),
    .trap_wr    (trap_wr),
    .trap_wdata (trap_wdata),
    .trap_en    (trap_en),
    .trap_irq   (trap_irq),
    .exc_start  (exc_start),
    .stack_addr (stack_addr)
  );

  always @(posedge clk) begin
    int  o_age;
    bit  o_irq, o_exc, busy, mhit, take;
    cycles++;
    if (!rst_n) begin
      m_age = 0; m_irq = 0; m_exc = 0; m_stack = '0; m_trap = '0;
    end else begin
      o_age = m_age; o_irq = m_irq; o_exc = m_exc;
      busy  = (o_age != 0) || o_irq || o_exc;
      mhit  = trap_en && bus_valid && bus_fetch &&
              ((bus_addr / 2) == (m_trap / 2)) && !busy;
      take  = o_irq && insn_done && trap_en;
      m_exc = take;
      if (take) m_stack = resume_pc;
      if (!trap_en) begin
        m_irq = 0; m_age = 0;
      end else begin
        if (take) m_irq = 0;
        else if (o_age == DLY - 1) m_irq = 1;
        if (o_age == DLY - 1) m_age = 0;
        else if (o_age > 0) m_age = o_age + 1;
        else if (mhit) m_age = 1;
      end
      if (trap_wr) m_trap = trap_wdata;
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-state comparison against the model
  always @(negedge clk) begin
    if (cycles >= 2 && !finished) begin
      chk("R1 model trap_irq", {23'd0, trap_irq}, {23'd0, m_irq});
      chk("R4 model exc_start", {23'd0, exc_start}, {23'd0, m_exc});
      chk("R5 model stack_addr", stack_addr, m_stack);
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input bit v, input bit f, input logic [23:0] a,
                     input bit d, input logic [23:0] npc,
                     input bit w = 1'b0, input logic [23:0] wd = '0);
    bus_valid = v; bus_fetch = f; bus_addr = a;
    insn_done = d; resume_pc = npc;
    trap_wr = w; trap_wdata = wd;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 24'h0, 0, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 trap_irq", {23'd0, trap_irq}, 24'd0);
    chk("R9 exc_start", {23'd0, exc_start}, 24'd0);
    chk("R9 stack_addr", stack_addr, 24'd0);
    rst_n = 1'b1;
    trap_en = 1'b1;
    idle();

    // stacked address is the trap address itself
    cyc(0, 0, 24'h0, 0, 24'h0, 1, 24'h000260);
    cyc(1, 1, 24'h00025E, 0, 24'h0);
    cyc(1, 1, 24'h000260, 0, 24'h0);
    chk("R1 irq low one state after hit", {23'd0, trap_irq}, 24'd0);
    cyc(1, 0, 24'h000000, 0, 24'h0);
    chk("R1 irq high two states after hit", {23'd0, trap_irq}, 24'd1);
    cyc(1, 1, 24'h000262, 1, 24'h000260);
    chk("R4 exc_start on completion", {23'd0, exc_start}, 24'd1);
    chk("R5 stack equals trap address", stack_addr, 24'h000260);
    chk("R6 irq drops with exc_start", {23'd0, trap_irq}, 24'd0);
    idle();
    chk("R4 exc_start one state only", {23'd0, exc_start}, 24'd0);
    idle();

    // trapped instruction finishes before the request
    cyc(1, 1, 24'h00025E, 0, 24'h0);
    cyc(1, 1, 24'h000260, 1, 24'h000260);
    cyc(1, 1, 24'h000262, 1, 24'h000262);
    chk("R4 completion before request ignored", {23'd0, exc_start}, 24'd0);
    chk("R1 irq raised", {23'd0, trap_irq}, 24'd1);
    cyc(1, 1, 24'h000264, 1, 24'h000262);
    chk("R5 stack is following address", stack_addr, 24'h000262);
    idle(); idle();

    // request held, repeated hits ignored
    cyc(1, 1, 24'h000260, 0, 24'h0);
    cyc(1, 1, 24'h000260, 0, 24'h0);
    cyc(1, 1, 24'h000260, 0, 24'h0);
    cyc(1, 1, 24'h000260, 0, 24'h0);
    cyc(1, 1, 24'h000260, 0, 24'h0);
    chk("R6 irq held without completion", {23'd0, trap_irq}, 24'd1);
    cyc(1, 1, 24'h000260, 1, 24'h000260);
    chk("R6 exc after hold", {23'd0, exc_start}, 24'd1);
    idle(); idle(); idle();
    chk("R7 no second request", {23'd0, trap_irq}, 24'd0);

    // data accesses and idle states at the trap address
    cyc(1, 0, 24'h000260, 0, 24'h0);
    cyc(0, 1, 24'h000260, 0, 24'h0);
    idle();
    chk("R2 data read no request", {23'd0, trap_irq}, 24'd0);
    idle();
    chk("R2 idle state no request", {23'd0, trap_irq}, 24'd0);

    // odd trap value, bit 0 ignored, upper bits compared
    cyc(0, 0, 24'h0, 0, 24'h0, 1, 24'h012345);
    cyc(1, 1, 24'h812344, 0, 24'h0);
    idle();
    chk("R3 upper bit mismatch no request", {23'd0, trap_irq}, 24'd0);
    cyc(1, 1, 24'h012344, 0, 24'h0);
    idle();
    chk("R3 bit 0 ignored", {23'd0, trap_irq}, 24'd1);
    cyc(0, 0, 24'h0, 1, 24'h012346);
    chk("R5 stack capture", stack_addr, 24'h012346);
    idle();

    // write in the same state as the fetch uses the old value
    cyc(1, 1, 24'h000400, 0, 24'h0, 1, 24'h000400);
    idle();
    chk("R3 write effective next state", {23'd0, trap_irq}, 24'd0);
    idle();

    // enable cancels in-flight hit
    cyc(1, 1, 24'h000400, 0, 24'h0);
    trap_en = 1'b0;
    idle();
    trap_en = 1'b1;
    idle();
    chk("R8 in-flight hit cancelled", {23'd0, trap_irq}, 24'd0);
    idle();

    // disabled fetch makes no hit
    trap_en = 1'b0;
    cyc(1, 1, 24'h000400, 0, 24'h0);
    trap_en = 1'b1;
    idle();
    chk("R8 disabled fetch no request", {23'd0, trap_irq}, 24'd0);
    idle();

    // disable while request raised
    cyc(1, 1, 24'h000400, 0, 24'h0);
    idle();
    chk("R1 irq before disable", {23'd0, trap_irq}, 24'd1);
    trap_en = 1'b0;
    cyc(0, 0, 24'h0, 1, 24'h000777);
    chk("R8 irq dropped", {23'd0, trap_irq}, 24'd0);
    chk("R8 no exception while disabled", {23'd0, exc_start}, 24'd0);
    chk("R8 stack unchanged", stack_addr, 24'h012346);
    trap_en = 1'b1;
    idle(); idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule